// File: doc/BRIEF.md
# Flash Converter Digital Back End

This block sits behind the comparator bank of a flash converter with a resolution of `RES_BITS` bits. Each cycle it sees a thermometer word of 2^RES_BITS−1 comparator decisions, with position 0 at the bottom of the ladder. A start strobe arrives asynchronously to the system clock. When the selected strobe edge is seen, the block takes one snapshot of the thermometer word. It clears any comparator listed as failed in a fault mask, then reduces the word to a binary code by taking the highest asserted position.

The code can be mapped to an unsigned range or to an offset two's-complement range. It is held for a programmable number of clock cycles and then written to the output register. A completion flag marks the cycle in which the new value appears. If a new trigger arrives before a held result has been written, that result is dropped and the newer conversion replaces it.

Top module: `flash_backend`

## Requirements
- R1: While `rstN` is low, `codeOut` reads 0 and `doneOut` reads 0.
- R2: The code equals p+1, where p is the highest position whose masked comparator bit is 1. If no bit is set, the code is 0. Set bits below a zero still count, and only the top set bit decides.
- R3: A comparator whose `faultMask` bit is 1 is treated as 0 before encoding, so codes that depend on that position can never be produced.
- R4: With `bipolarEn` = 0 the code is unsigned, 0 to 2^RES_BITS−1. With `bipolarEn` = 1 the MSB of that code is inverted, which gives a two's-complement value equal to the unsigned code minus 2^(RES_BITS−1).
- R5: `edgeSel` = 2'b00 triggers on a rising strobe, 2'b01 on a falling strobe, and 2'b10 or 2'b11 on either edge. A strobe edge that is not selected starts nothing: `codeOut` keeps its value and `doneOut` stays 0.
- R6: For a latency value L, the result is written on the rising clock edge that comes L+3 edges after the first edge that samples the new strobe level.
- R7: `doneOut` is 1 for exactly one clock cycle, the cycle in which the new result first appears on `codeOut`.
- R8: The thermometer word, mask and polarity are captured on the edge that follows trigger detection. Changes after that edge do not alter the pending result.
- R9: A trigger that arrives while a result is still pending discards that result and restarts the latency count. Only the newer result is written, with one `doneOut` pulse, and `codeOut` keeps its earlier value until then.
- R10: Between writes, `codeOut` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| thermoIn | input | 2^RES_BITS−1 | Comparator decisions, bit 0 lowest on the ladder |
| faultMask | input | 2^RES_BITS−1 | 1 marks a failed comparator, which is forced to 0 |
| startStrobe | input | 1 | Asynchronous start-conversion strobe |
| edgeSel | input | 2 | 00 rising, 01 falling, 1x both edges |
| bipolarEn | input | 1 | 1 selects the offset two's-complement output |
| latency | input | LAT_W | Extra clock cycles before the result is written |
| codeOut | output | RES_BITS | Converted code |
| doneOut | output | 1 | One-cycle pulse when `codeOut` is updated |

## Verification
The hardest case to reach is a second trigger that lands inside the latency window of an earlier one. From the ports it has to be timed against an internal capture edge that lies behind the synchronizer. The stimulus uses the either-edge mode with a long latency. It toggles the strobe a fixed number of cycles after the first capture and changes the thermometer word at the same moment. It then confirms three things: the old code is still held just before the restarted window expires, the new code appears at the expected edge, and exactly one completion pulse occurs across the whole sequence.

// File: rtl/flash_backend_pkg.sv
package flash_backend_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic capture;
    logic write;
  } dp_strobe_t;

endpackage

// File: rtl/flash_backend_enc.sv
module flash_backend_enc #(
  parameter int RES_BITS = 4,
  localparam int TAPS = (1 << RES_BITS) - 1
) (
  input  logic [TAPS-1:0]     thermo,
  output logic [RES_BITS-1:0] code
);

  logic [TAPS-1:0] aboveAny;
  logic [TAPS-1:0] isTop;

  assign aboveAny[TAPS-1] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < TAPS - 1; g++) begin : gen_above
      assign aboveAny[g] = aboveAny[g+1] | thermo[g+1];
    end
    for (g = 0; g < TAPS; g++) begin : gen_top
      assign isTop[g] = thermo[g] & ~aboveAny[g];
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (isTop[i]) code = code | RES_BITS'(i + 1);
    end
  end

  always_comb begin
    assert_single_top_R2: assert ($onehot0(isTop));
    if ((thermo & (thermo + 1'b1)) == '0) begin
      assert_clean_count_R2: assert (code == RES_BITS'($countones(thermo)));
    end
  end

endmodule

// File: rtl/flash_backend_ctrl.sv
module flash_backend_ctrl
  import flash_backend_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic [1:0]       edgeSel,
  input  logic [LAT_W-1:0] latency,
  output dp_strobe_t       strobes
);

  logic syncA, syncB, prevQ;
  logic riseHit, fallHit, trig;
  logic pendingQ;
  logic [LAT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncA <= startStrobe;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseHit = syncB & ~prevQ;
  assign fallHit = ~syncB & prevQ;

  always_comb begin
    case (edgeSel)
      EDGE_RISE: trig = riseHit;
      EDGE_FALL: trig = fallHit;
      default:   trig = riseHit | fallHit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      cntQ     <= '0;
    end else if (trig) begin
      pendingQ <= 1'b1;
      cntQ     <= latency;
    end else if (pendingQ) begin
      if (cntQ == '0) pendingQ <= 1'b0;
      else            cntQ     <= cntQ - LAT_W'(1);
    end
  end

  assign strobes.capture = trig;
  assign strobes.write   = pendingQ && (cntQ == '0) && !trig;

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> pendingQ && (cntQ == $past(latency)));

  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !trig && cntQ != '0) |=> pendingQ && (cntQ == $past(cntQ) - LAT_W'(1)));

endmodule

// File: rtl/flash_backend_dp.sv
module flash_backend_dp
  import flash_backend_pkg::*;
#(
  parameter int RES_BITS = 4,
  localparam int TAPS = (1 << RES_BITS) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TAPS-1:0]     thermoIn,
  input  logic [TAPS-1:0]     faultMask,
  input  logic                bipolarEn,
  input  dp_strobe_t          strobes,
  output logic [RES_BITS-1:0] codeOut,
  output logic                doneOut
);

  localparam logic [RES_BITS-1:0] MSB_FLIP = RES_BITS'(1) << (RES_BITS - 1);

  logic [TAPS-1:0]     maskedThermo;
  logic [RES_BITS-1:0] rawCode, mappedCode;
  logic [RES_BITS-1:0] capQ, codeQ;
  logic                doneQ;

  assign maskedThermo = thermoIn & ~faultMask;

  flash_backend_enc #(.RES_BITS(RES_BITS)) u_enc (
    .thermo (maskedThermo),
    .code   (rawCode)
  );

  assign mappedCode = bipolarEn ? (rawCode ^ MSB_FLIP) : rawCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ  <= '0;
      codeQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (strobes.capture) capQ  <= mappedCode;
      if (strobes.write)   codeQ <= capQ;
      doneQ <= strobes.write;
    end
  end

  assign codeOut = codeQ;
  assign doneOut = doneQ;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.write |=> $stable(codeQ));

  assert_write_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.write |=> (codeQ == $past(capQ)) && doneQ);

endmodule

// File: rtl/flash_backend.sv
module flash_backend
  import flash_backend_pkg::*;
#(
  parameter int RES_BITS = 4,
  parameter int LAT_W    = 4,
  localparam int TAPS = (1 << RES_BITS) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TAPS-1:0]     thermoIn,
  input  logic [TAPS-1:0]     faultMask,
  input  logic                startStrobe,
  input  logic [1:0]          edgeSel,
  input  logic                bipolarEn,
  input  logic [LAT_W-1:0]    latency,
  output logic [RES_BITS-1:0] codeOut,
  output logic                doneOut
);

  dp_strobe_t strobes;

  flash_backend_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .edgeSel     (edgeSel),
    .latency     (latency),
    .strobes     (strobes)
  );

  flash_backend_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .thermoIn  (thermoIn),
    .faultMask (faultMask),
    .bipolarEn (bipolarEn),
    .strobes   (strobes),
    .codeOut   (codeOut),
    .doneOut   (doneOut)
  );

endmodule

// File: tb/flash_backend_bench.sv
module flash_backend_bench;

  localparam int RES_BITS = 4;
  localparam int LAT_W    = 4;
  localparam int TAPS     = (1 << RES_BITS) - 1;

  typedef struct packed {
    logic [TAPS-1:0]     th;
    logic [TAPS-1:0]     mk;
    logic                bip;
    logic [LAT_W-1:0]    lat;
    logic [RES_BITS-1:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{15'h0000, 15'h0000, 1'b0, 4'd0,  4'd0},
    '{15'h7FFF, 15'h0000, 1'b0, 4'd0,  4'd15},
    '{15'h007F, 15'h0000, 1'b0, 4'd2,  4'd7},
    '{15'h0001, 15'h0000, 1'b1, 4'd1,  4'h9},
    '{15'h00FF, 15'h0000, 1'b1, 4'd0,  4'h0},
    '{15'h0000, 15'h0000, 1'b1, 4'd3,  4'h8},
    '{15'h01FF, 15'h0100, 1'b0, 4'd0,  4'd8},
    '{15'h7FFF, 15'h4000, 1'b0, 4'd3,  4'd14},
    '{15'h0105, 15'h0000, 1'b0, 4'd1,  4'd9},
    '{15'h3FFF, 15'h0000, 1'b0, 4'd15, 4'd14}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [TAPS-1:0] thermoIn, faultMask;
  logic startStrobe;
  logic [1:0] edgeSel;
  logic bipolarEn;
  logic [LAT_W-1:0] latency;
  logic [RES_BITS-1:0] codeOut;
  logic doneOut;

  int checks = 0;
  int failures = 0;
  int doneCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN && doneOut) doneCount++;

  flash_backend #(.RES_BITS(RES_BITS), .LAT_W(LAT_W)) u_flash_backend (
    .clk(clk), .rstN(rstN), .thermoIn(thermoIn), .faultMask(faultMask),
    .startStrobe(startStrobe), .edgeSel(edgeSel), .bipolarEn(bipolarEn),
    .latency(latency), .codeOut(codeOut), .doneOut(doneOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doConv(input logic [TAPS-1:0] th, input logic [TAPS-1:0] mk,
                        input logic bip, input logic [LAT_W-1:0] lat,
                        input logic [RES_BITS-1:0] exp, input logic level,
                        input string req);
    @(negedge clk);
    thermoIn = th; faultMask = mk; bipolarEn = bip; latency = lat;
    startStrobe = level;
    repeat (int'(lat) + 4) @(posedge clk);
    @(negedge clk);
    chk({req, " code"}, codeOut, exp);
    chk("R6 done at L+3 edges", doneOut, 1);
    @(negedge clk);
    chk("R7 done one cycle", doneOut, 0);
  endtask

  task automatic quiet(input logic level, input logic [RES_BITS-1:0] held, input string req);
    int base;
    @(negedge clk);
    base = doneCount;
    startStrobe = level;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk({req, " code held"}, codeOut, held);
    chk({req, " no done"}, doneCount, base);
  endtask

  initial begin
    int base;
    rstN = 1'b0; thermoIn = '0; faultMask = '0; startStrobe = 1'b0;
    edgeSel = 2'b00; bipolarEn = 1'b0; latency = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset code", codeOut, 0);
    chk("R1 reset done", doneOut, 0);
    rstN = 1'b1;

    // R2 R3 R4 vectors in rising mode; falling strobe must be ignored (R5, R10)
    for (int i = 0; i < 10; i++) begin
      doConv(VECS[i].th, VECS[i].mk, VECS[i].bip, VECS[i].lat, VECS[i].exp, 1'b1,
             "R2/R3/R4 vector");
      quiet(1'b0, VECS[i].exp, "R5 falling ignored in rise mode");
    end

    // R5 falling mode: rising ignored, falling converts
    edgeSel = 2'b01;
    thermoIn = 15'h0003; latency = 4'd1; bipolarEn = 1'b0;
    quiet(1'b1, 4'd14, "R5 rising ignored in fall mode");
    doConv(15'h0003, 15'h0000, 1'b0, 4'd1, 4'd2, 1'b0, "R5 fall mode");

    // R5 both edges
    edgeSel = 2'b10;
    doConv(15'h001F, 15'h0000, 1'b0, 4'd0, 4'd5, 1'b1, "R5 both rise");
    doConv(15'h3FFF, 15'h0000, 1'b1, 4'd2, 4'd6, 1'b0, "R5 both fall bipolar R4");

    // R8: input change after capture edge does not matter
    @(negedge clk);
    thermoIn = 15'h000F; faultMask = '0; bipolarEn = 1'b0; latency = 4'd2;
    startStrobe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    thermoIn = 15'h7FFF; bipolarEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 captured snapshot", codeOut, 4);
    chk("R8 done", doneOut, 1);

    // R9: retrigger during pending window
    repeat (3) @(negedge clk);
    base = doneCount;
    thermoIn = 15'h003F; bipolarEn = 1'b0; latency = 4'd6;
    startStrobe = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    thermoIn = 15'h0FFF;
    startStrobe = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R9 old code held", codeOut, 4);
    chk("R9 no early done", doneOut, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 new code", codeOut, 12);
    chk("R9 done", doneOut, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 single done", doneCount, base + 1);
    chk("R10 held after", codeOut, 12);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule